// File: doc/BRIEF.md
# Dual-Slot Row/Column Command Packer

This block merges two command streams into one command word per controller clock cycle. One stream carries row commands (activate, precharge) and the other carries column commands (read, write). Each controller cycle spans several memory clocks: two at half rate and four at quarter rate. In both rates the output word has two command slots, so one row command and one column command can be issued in the same controller cycle.

The two commands of a cycle must be of opposite kinds and sit in opposite slots. Either order is allowed. When both kinds are waiting, the block alternates the order from one such cycle to the next, so that neither kind always lands on the earlier memory clock. A lone command always goes in slot 0. The rate comes only from the `RATE` parameter; there is no runtime setting. The output word is laid out per memory-clock phase. Slot 0 sits on phase 0, slot 1 sits on phase `RATE/2`, and every other phase carries a no-operation.

Top module: `slot_packer`

## Requirements
- R1: While `rst` is high, both ready outputs are low. All phase command, bank and address fields are zero.
- R2: Command codes are 3 bits wide: 000 no-operation, 001 activate, 010 precharge, 011 read, 100 write. A row command is activate when `rowIsPre`=0 and precharge when it is 1. A column command is read when `colIsWr`=0 and write when it is 1. Each command carries its bank and address unchanged.
- R3: When only a row command is presented, it appears in slot 0 and slot 1 is a no-operation.
- R4: When only a column command is presented, it appears in slot 0 and slot 1 is a no-operation.
- R5: When both kinds are presented in one cycle, both are issued in that word, one in each slot.
- R6: The first cycle with both kinds after reset puts the row command in slot 0. Each later cycle with both kinds swaps the order of the previous one. Cycles with a single kind, or with no command, leave the order unchanged.
- R7: Slot 0 drives phase 0 and slot 1 drives phase `RATE/2` (`RATE` is 2 or 4). Each phase p occupies bits [p*3+:3] of `phaseCmd`, [p*BANK_W+:BANK_W] of `phaseBank` and [p*ADDR_W+:ADDR_W] of `phaseAddr`. All other phases carry code 000 with zero bank and address.
- R8: Out of reset, both ready outputs are high and every presented command is accepted. It appears in the output word registered on the next clock edge.
- R9: No output word ever holds two row commands or two column commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rowValid | input | 1 | Row command offered |
| rowIsPre | input | 1 | 0 activate, 1 precharge |
| rowBank | input | BANK_W | Row command bank |
| rowAddr | input | ADDR_W | Row command address |
| rowReady | output | 1 | Row command accepted |
| colValid | input | 1 | Column command offered |
| colIsWr | input | 1 | 0 read, 1 write |
| colBank | input | BANK_W | Column command bank |
| colAddr | input | ADDR_W | Column command address |
| colReady | output | 1 | Column command accepted |
| phaseCmd | output | RATE*3 | Command code for each memory-clock phase |
| phaseBank | output | RATE*BANK_W | Bank for each phase |
| phaseAddr | output | RATE*ADDR_W | Address for each phase |

## Verification
A row command and a column command can fall in the same controller cycle. In that case slot assignment and order alternation act together. The bench provokes this with runs of consecutive dual cycles, and inserts single-kind and idle cycles between them to show that those cycles keep the order. A scoreboard holds its own copy of the order bit. For every word it predicts the complete phase layout and compares it field by field, so a wrong kind, a wrong slot or a stale order is all reported.

// File: rtl/slot_packer_pkg.sv
package slot_packer_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP = 3'b000,
    CMD_ACT = 3'b001,
    CMD_PRE = 3'b010,
    CMD_RD  = 3'b011,
    CMD_WR  = 3'b100
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeRow;
    logic takeCol;
    logic rowSlot;
    logic colSlot;
  } strobe_t;
endpackage

// File: rtl/slot_packer_ctrl.sv
module slot_packer_ctrl
  import slot_packer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rowValid,
  input  logic    colValid,
  output logic    rowReady,
  output logic    colReady,
  output strobe_t strb
);
  logic colFirst;
  logic dualCyc;

  assign rowReady = !rst;
  assign colReady = !rst;
  assign dualCyc  = strb.takeRow && strb.takeCol;

  always_comb begin
    strb.takeRow = rowValid && rowReady;
    strb.takeCol = colValid && colReady;
    strb.rowSlot = 1'b0;
    strb.colSlot = 1'b0;
    if (strb.takeRow && strb.takeCol) begin
      strb.rowSlot = colFirst;
      strb.colSlot = !colFirst;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) colFirst <= 1'b0;
    else if (dualCyc) colFirst <= !colFirst;
  end

  // R6
  alt_order_chk: assert property (@(posedge clk) disable iff (rst)
    dualCyc |=> (colFirst != $past(colFirst)));
  // R6
  hold_order_chk: assert property (@(posedge clk) disable iff (rst)
    !dualCyc |=> $stable(colFirst));
endmodule

// File: rtl/slot_packer_dp.sv
module slot_packer_dp
  import slot_packer_pkg::*;
#(
  parameter int RATE   = 4,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strb,
  input  logic                     rowIsPre,
  input  logic [BANK_W-1:0]        rowBank,
  input  logic [ADDR_W-1:0]        rowAddr,
  input  logic                     colIsWr,
  input  logic [BANK_W-1:0]        colBank,
  input  logic [ADDR_W-1:0]        colAddr,
  output logic [RATE*CMD_W-1:0]    phaseCmd,
  output logic [RATE*BANK_W-1:0]   phaseBank,
  output logic [RATE*ADDR_W-1:0]   phaseAddr
);
  localparam int SLOT1_PH = RATE / 2;

  cmd_e              slotCmd  [2];
  logic [BANK_W-1:0] slotBank [2];
  logic [ADDR_W-1:0] slotAddr [2];
  cmd_e              rowCode, colCode;

  assign rowCode = rowIsPre ? CMD_PRE : CMD_ACT;
  assign colCode = colIsWr ? CMD_WR : CMD_RD;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      slotCmd[s]  = CMD_NOP;
      slotBank[s] = '0;
      slotAddr[s] = '0;
      if (strb.takeRow && (int'(strb.rowSlot) == s)) begin
        slotCmd[s]  = rowCode;
        slotBank[s] = rowBank;
        slotAddr[s] = rowAddr;
      end else if (strb.takeCol && (int'(strb.colSlot) == s)) begin
        slotCmd[s]  = colCode;
        slotBank[s] = colBank;
        slotAddr[s] = colAddr;
      end
    end
  end

  for (genvar p = 0; p < RATE; p++) begin : g_phase
    if (p == 0 || p == SLOT1_PH) begin : g_used
      localparam int S = (p == 0) ? 0 : 1;
      always_ff @(posedge clk) begin
        if (rst) begin
          phaseCmd [p*CMD_W  +: CMD_W]  <= '0;
          phaseBank[p*BANK_W +: BANK_W] <= '0;
          phaseAddr[p*ADDR_W +: ADDR_W] <= '0;
        end else begin
          phaseCmd [p*CMD_W  +: CMD_W]  <= slotCmd[S];
          phaseBank[p*BANK_W +: BANK_W] <= slotBank[S];
          phaseAddr[p*ADDR_W +: ADDR_W] <= slotAddr[S];
        end
      end
    end else begin : g_idle
      assign phaseCmd [p*CMD_W  +: CMD_W]  = '0;
      assign phaseBank[p*BANK_W +: BANK_W] = '0;
      assign phaseAddr[p*ADDR_W +: ADDR_W] = '0;
    end
  end

  // checker view of the issued word
  int rowCnt, colCnt;
  always_comb begin
    rowCnt = 0;
    colCnt = 0;
    for (int p = 0; p < RATE; p++) begin
      if (phaseCmd[p*CMD_W +: CMD_W] inside {CMD_ACT, CMD_PRE}) rowCnt++;
      if (phaseCmd[p*CMD_W +: CMD_W] inside {CMD_RD, CMD_WR}) colCnt++;
    end
  end

  // R9
  one_row_chk: assert property (@(posedge clk) disable iff (rst) rowCnt <= 1);
  // R9
  one_col_chk: assert property (@(posedge clk) disable iff (rst) colCnt <= 1);
  // R3
  row_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.takeRow && !strb.takeCol) |=>
      (phaseCmd[0 +: CMD_W] inside {CMD_ACT, CMD_PRE}) &&
      (phaseCmd[SLOT1_PH*CMD_W +: CMD_W] == CMD_NOP));
  // R4
  col_alone_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.takeCol && !strb.takeRow) |=>
      (phaseCmd[0 +: CMD_W] inside {CMD_RD, CMD_WR}) &&
      (phaseCmd[SLOT1_PH*CMD_W +: CMD_W] == CMD_NOP));
  // R5
  both_issued_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.takeCol && strb.takeRow) |=> (rowCnt == 1 && colCnt == 1));
endmodule

// File: rtl/slot_packer.sv
module slot_packer
  import slot_packer_pkg::*;
#(
  parameter int RATE   = 4,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rowValid,
  input  logic                   rowIsPre,
  input  logic [BANK_W-1:0]      rowBank,
  input  logic [ADDR_W-1:0]      rowAddr,
  output logic                   rowReady,
  input  logic                   colValid,
  input  logic                   colIsWr,
  input  logic [BANK_W-1:0]      colBank,
  input  logic [ADDR_W-1:0]      colAddr,
  output logic                   colReady,
  output logic [RATE*3-1:0]      phaseCmd,
  output logic [RATE*BANK_W-1:0] phaseBank,
  output logic [RATE*ADDR_W-1:0] phaseAddr
);
  strobe_t strb;

  initial rate_ok_chk: assert (RATE == 2 || RATE == 4);

  slot_packer_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rowValid(rowValid), .colValid(colValid),
    .rowReady(rowReady), .colReady(colReady), .strb(strb)
  );

  slot_packer_dp #(.RATE(RATE), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .rowIsPre(rowIsPre), .rowBank(rowBank), .rowAddr(rowAddr),
    .colIsWr(colIsWr), .colBank(colBank), .colAddr(colAddr),
    .phaseCmd(phaseCmd), .phaseBank(phaseBank), .phaseAddr(phaseAddr)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (phaseCmd == '0 && phaseBank == '0 && phaseAddr == '0));
endmodule

// File: tb/sim_slot_packer.sv
module sim_slot_packer;
  localparam int RATE = 4;
  localparam int BW = 3;
  localparam int AW = 14;
  localparam int HALF = RATE / 2;

  logic clk = 0;
  logic rst = 1;
  logic rowValid = 0, rowIsPre = 0, colValid = 0, colIsWr = 0;
  logic [BW-1:0] rowBank = '0, colBank = '0;
  logic [AW-1:0] rowAddr = '0, colAddr = '0;
  logic rowReady, colReady;
  logic [RATE*3-1:0]  phaseCmd;
  logic [RATE*BW-1:0] phaseBank;
  logic [RATE*AW-1:0] phaseAddr;

  int total = 0, bad = 0;
  logic benchColFirst = 0;

  typedef struct {
    logic [RATE*3-1:0]  c;
    logic [RATE*BW-1:0] b;
    logic [RATE*AW-1:0] a;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = !clk;

  slot_packer #(.RATE(RATE), .BANK_W(BW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .rowValid(rowValid), .rowIsPre(rowIsPre),
    .rowBank(rowBank), .rowAddr(rowAddr), .rowReady(rowReady),
    .colValid(colValid), .colIsWr(colIsWr), .colBank(colBank),
    .colAddr(colAddr), .colReady(colReady),
    .phaseCmd(phaseCmd), .phaseBank(phaseBank), .phaseAddr(phaseAddr)
  );

  task automatic check(input bit ok, input string tag, input string got, input string want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%s expected=%s", tag, got, want);
    end
  endtask

  // driver: present one cycle of commands and predict the word
  task automatic step(input bit rv, input bit rp, input int rb, input int ra,
                      input bit cv, input bit cw, input int cb, input int ca,
                      input string tag);
    exp_t e;
    logic [2:0] rc, cc;
    @(negedge clk);
    rowValid = rv; rowIsPre = rp; rowBank = BW'(rb); rowAddr = AW'(ra);
    colValid = cv; colIsWr = cw; colBank = BW'(cb); colAddr = AW'(ca);
    // R8 ready while out of reset
    check(rowReady && colReady, "R8 ready", $sformatf("%b%b", rowReady, colReady), "11");
    rc = rp ? 3'b010 : 3'b001;
    cc = cw ? 3'b100 : 3'b011;
    e.c = '0; e.b = '0; e.a = '0; e.tag = tag;
    if (rv && cv) begin
      if (benchColFirst) begin
        e.c[0 +: 3] = cc; e.b[0 +: BW] = BW'(cb); e.a[0 +: AW] = AW'(ca);
        e.c[HALF*3 +: 3] = rc; e.b[HALF*BW +: BW] = BW'(rb); e.a[HALF*AW +: AW] = AW'(ra);
      end else begin
        e.c[0 +: 3] = rc; e.b[0 +: BW] = BW'(rb); e.a[0 +: AW] = AW'(ra);
        e.c[HALF*3 +: 3] = cc; e.b[HALF*BW +: BW] = BW'(cb); e.a[HALF*AW +: AW] = AW'(ca);
      end
      benchColFirst = !benchColFirst;
    end else if (rv) begin
      e.c[0 +: 3] = rc; e.b[0 +: BW] = BW'(rb); e.a[0 +: AW] = AW'(ra);
    end else if (cv) begin
      e.c[0 +: 3] = cc; e.b[0 +: BW] = BW'(cb); e.a[0 +: AW] = AW'(ca);
    end
    expQ.push_back(e);
  endtask

  // monitor: compare one word per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check(phaseCmd == e.c, {e.tag, " cmd"}, $sformatf("%h", phaseCmd), $sformatf("%h", e.c));
        check(phaseBank == e.b, {e.tag, " bank"}, $sformatf("%h", phaseBank), $sformatf("%h", e.b));
        check(phaseAddr == e.a, {e.tag, " addr"}, $sformatf("%h", phaseAddr), $sformatf("%h", e.a));
      end
    end
  end

  initial begin
    #200000;
    check(0, "watchdog", "timeout", "finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rowValid = 1; colValid = 1; rowBank = 3'd5; colAddr = 14'h1ff;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!rowReady && !colReady, "R1 ready", $sformatf("%b%b", rowReady, colReady), "00");
    check(phaseCmd == '0 && phaseBank == '0 && phaseAddr == '0, "R1 outputs",
          $sformatf("%h", phaseCmd), "0");
    rst = 0; rowValid = 0; colValid = 0;
    // R2 R3 row-only
    step(1, 0, 3, 16'h0123, 0, 0, 0, 0, "R3 R2 act alone");
    step(1, 1, 6, 16'h3abc, 0, 0, 0, 0, "R3 R2 pre alone");
    // R4 column-only
    step(0, 0, 0, 0, 1, 0, 2, 16'h0040, "R4 R2 rd alone");
    step(0, 0, 0, 0, 1, 1, 7, 16'h3fff, "R4 R2 wr alone");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7 idle word");
    // R5 R6 R7 dual runs
    step(1, 0, 1, 16'h0111, 1, 0, 4, 16'h0222, "R5 R6 dual first row-led");
    step(1, 1, 2, 16'h0333, 1, 1, 5, 16'h0444, "R6 R9 dual col-led");
    step(1, 0, 3, 16'h0555, 1, 0, 6, 16'h0666, "R6 R7 dual row-led");
    step(1, 0, 7, 16'h0777, 0, 0, 0, 0, "R6 single row keeps order");
    step(0, 0, 0, 0, 1, 1, 1, 16'h0888, "R6 single col keeps order");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6 idle keeps order");
    step(1, 1, 0, 16'h0999, 1, 0, 3, 16'h0aaa, "R6 R9 dual col-led after gap");
    step(1, 0, 4, 16'h0bbb, 1, 1, 2, 16'h0ccc, "R5 R8 dual row-led");
    for (int i = 0; i < 8; i++)
      step(1, i[0], i, 16'h1000 + i, 1, i[1], 7 - i, 16'h2000 + i, "R6 R9 back-to-back duals");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7 final idle");
    @(posedge clk); #2;
    check(expQ.size() == 0, "R8 all words seen", $sformatf("%0d", expQ.size()), "0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule